// File: doc/BRIEF.md
# Sixteen-Cell Logic Block Cluster

This block models one cluster of sixteen configurable logic cells as found in a programmable fabric. Each cell holds a four-input lookup function, a full-adder mode and one flip-flop. The cells share a small set of cluster-wide controls: two clock-enable slots, two asynchronous clears, one synchronous clear and one synchronous load. A global reset sits above all of these. A ripple carry path and a register shift path run through the cells from cell 0 to cell 15. With them the cluster can act as a 16-bit adder whose carry-out feeds the next cluster, or as a 16-stage shift register that leaves the lookup functions free for other logic.

Per-cell configuration sets the cell mode and the register data source. It also picks which enable slot and which asynchronous clear the cell follows. A cluster-wide option turns on the synchronous load. When the load is on, enable slot 1 is no longer available. A configuration error flag reports settings that break the sharing rules. There is a single real clock, and the two clock slots are modelled as enables.

Top module: `lgc_cluster`

## Requirements
- R1: A cell in arithmetic mode (cfgArith bit set) outputs dA^dB^carry on combOut and passes the majority of dA, dB and its carry-in to the next cell. With all cells in this mode, {carryOut, combOut} equals dA + dB + carryIn as 16-bit unsigned numbers.
- R2: A cell in lookup mode outputs bit k of its 16-bit mask on combOut, where the mask is cfgLut[16*i +: 16] and k = {dD,dC,dB,dA}. The cell passes its carry-in unchanged.
- R3: An enabled cell that is not packed and has no chain select captures its own combOut on the rising clock edge.
- R4: A cell with cfgChain set captures the previous cell's register. Cell 0 captures chainIn. chainOut is the register of cell 15, so a full chain delays chainIn by 16 enabled edges.
- R5: A packed cell (cfgPack set) captures dD and ignores the synchronous clear and the synchronous load.
- R6: A cell with cfgClkSel 1 updates only when ena2 is high. A cell with cfgClkSel 0 updates only when ena1 is high. A disabled cell holds its value, including against the synchronous clear and load.
- R7: The synchronous clear zeroes every enabled, non-packed cell on the clock edge and takes priority over the synchronous load.
- R8: With useSload set, sload makes every enabled, non-packed cell load its dC input. With useSload clear, sload has no effect.
- R9: With useSload set, ena1 is ignored and slot-1 cells are treated as always enabled.
- R10: A high level on aclr1 or aclr2 clears, at once and without a clock, every cell whose cfgClrSel selects it (0 selects aclr1, 1 selects aclr2). Cells on the other clear are not touched.
- R11: rstN low clears every register at once and overrides all other controls.
- R12: cfgErr is high exactly when useSload is set and at least one cell selects slot 1 or is packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock |
| rstN | input | 1 | Global asynchronous reset, active low |
| ena1 | input | 1 | Enable for clock slot 1 |
| ena2 | input | 1 | Enable for clock slot 2 |
| aclr1 | input | 1 | Asynchronous clear line 1, active high |
| aclr2 | input | 1 | Asynchronous clear line 2, active high |
| sclr | input | 1 | Cluster-wide synchronous clear |
| sload | input | 1 | Cluster-wide synchronous load |
| useSload | input | 1 | Enables the synchronous load; enable slot 1 is then not available |
| cfgLut | input | 256 | Sixteen 16-bit lookup masks, cell i at [16*i +: 16] |
| cfgArith | input | 16 | Per-cell arithmetic mode |
| cfgChain | input | 16 | Per-cell register input from the previous cell |
| cfgPack | input | 16 | Per-cell packed register, fed from dD |
| cfgClkSel | input | 16 | Per-cell clock slot select (0 slot 1, 1 slot 2) |
| cfgClrSel | input | 16 | Per-cell asynchronous clear select (0 aclr1, 1 aclr2) |
| dA | input | 16 | Per-cell data input A |
| dB | input | 16 | Per-cell data input B |
| dC | input | 16 | Per-cell data input C, also the load value |
| dD | input | 16 | Per-cell data input D, also the packed register input |
| carryIn | input | 1 | Carry into cell 0 |
| chainIn | input | 1 | Register chain input to cell 0 |
| combOut | output | 16 | Per-cell combinational result |
| regOut | output | 16 | Per-cell register value |
| carryOut | output | 1 | Carry out of cell 15 |
| chainOut | output | 1 | Register of cell 15 |
| cfgErr | output | 1 | Illegal sharing of controls |

## Verification
The clocked properties assume that the asynchronous clears and the global reset stay high across at least one rising edge. The hold and shift checks are disabled while a clear is active, so a clear pulse that begins and ends between two edges would fall outside them. The stimulus changes every input on the falling edge, keeps each clear high for a full cycle, and changes the configuration only between clocked phases. Illegal configurations are driven on purpose only to observe cfgErr and the ignored enable.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  // Per-cell strobes resolved by the control from the shared controls
  typedef struct packed {
    logic en;     // cell clock slot enabled this cycle
    logic sclr;   // synchronous clear applies to this cell
    logic sload;  // synchronous load applies to this cell
    logic aclr;   // asynchronous clear (global reset folded in)
  } cellStb_t;
endpackage

// File: rtl/lgc_ctrl.sv
module lgc_ctrl
  import lgc_pkg::*;
#(
  parameter int NCELL = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ena1,
  input  logic                  ena2,
  input  logic                  aclr1,
  input  logic                  aclr2,
  input  logic                  sclr,
  input  logic                  sload,
  input  logic                  useSload,
  input  logic [NCELL-1:0]      cfgClkSel,
  input  logic [NCELL-1:0]      cfgClrSel,
  input  logic [NCELL-1:0]      cfgPack,
  output cellStb_t [NCELL-1:0]  stb,
  output logic                  cfgErr
);
  // slot 1 loses its enable when the synchronous load owns the line
  logic slot1En;
  logic loadLive;
  assign slot1En  = useSload | ena1;
  assign loadLive = useSload & sload;

  for (genvar i = 0; i < NCELL; i++) begin : g_stb
    assign stb[i].en    = cfgClkSel[i] ? ena2 : slot1En;
    assign stb[i].sclr  = sclr & ~cfgPack[i];
    assign stb[i].sload = loadLive & ~cfgPack[i];
    assign stb[i].aclr  = ~rstN | (cfgClrSel[i] ? aclr2 : aclr1);

    // R9: a slot-1 cell is never gated while the load option is on
    p_ena1_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
      (useSload && !cfgClkSel[i]) |-> stb[i].en);
  end

  assign cfgErr = useSload & ((|(~cfgClkSel)) | (|cfgPack));
endmodule

// File: rtl/lgc_cells.sv
module lgc_cells
  import lgc_pkg::*;
#(
  parameter int NCELL  = 16,
  parameter int LUT_IN = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cellStb_t [NCELL-1:0]     stb,
  input  logic [NCELL*(1<<LUT_IN)-1:0] cfgLut,
  input  logic [NCELL-1:0]         cfgArith,
  input  logic [NCELL-1:0]         cfgChain,
  input  logic [NCELL-1:0]         cfgPack,
  input  logic [NCELL-1:0]         dA,
  input  logic [NCELL-1:0]         dB,
  input  logic [NCELL-1:0]         dC,
  input  logic [NCELL-1:0]         dD,
  input  logic                     carryIn,
  input  logic                     chainIn,
  output logic [NCELL-1:0]         combOut,
  output logic [NCELL-1:0]         regOut,
  output logic                     carryOut,
  output logic                     chainOut
);
  localparam int LUTW = 1 << LUT_IN;

  logic [NCELL:0]   carry;
  logic [NCELL-1:0] q;

  assign carry[0] = carryIn;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [LUTW-1:0]   lutWord;
    logic [LUT_IN-1:0] sel;
    logic              sumBit;
    logic              majBit;
    logic              prevQ;
    logic              dNext;
    logic              clrBit;
    logic              qBit;

    assign lutWord = cfgLut[i*LUTW +: LUTW];
    assign sel     = LUT_IN'({dD[i], dC[i], dB[i], dA[i]});
    assign sumBit  = dA[i] ^ dB[i] ^ carry[i];
    assign majBit  = (dA[i] & dB[i]) | (carry[i] & (dA[i] ^ dB[i]));

    assign combOut[i]  = cfgArith[i] ? sumBit : lutWord[sel];
    assign carry[i+1]  = cfgArith[i] ? majBit : carry[i];

    if (i == 0) begin : g_head
      assign prevQ = chainIn;
    end else begin : g_link
      assign prevQ = q[i-1];
    end

    assign dNext  = cfgPack[i] ? dD[i] : (cfgChain[i] ? prevQ : combOut[i]);
    assign clrBit = stb[i].aclr;

    always_ff @(posedge clk or posedge clrBit) begin
      if (clrBit)              qBit <= 1'b0;
      else if (stb[i].en) begin
        if (stb[i].sclr)       qBit <= 1'b0;
        else if (stb[i].sload) qBit <= dC[i];
        else                   qBit <= dNext;
      end
    end

    assign q[i] = qBit;

    // R6: a register outside its enabled slot keeps its value
    p_hold_r6: assert property (@(posedge clk) disable iff (!rstN || clrBit)
      !stb[i].en |=> $stable(q[i]));

    // R7: synchronous clear wins over load and data
    p_sclr_r7: assert property (@(posedge clk) disable iff (!rstN || clrBit)
      (stb[i].en && stb[i].sclr) |=> (q[i] == 1'b0));

    if (i > 0) begin : g_shiftChk
      // R4: a chained cell takes its neighbour's previous value
      p_shift_r4: assert property (@(posedge clk) disable iff (!rstN || clrBit)
        (stb[i].en && cfgChain[i] && !cfgPack[i] && !stb[i].sclr && !stb[i].sload)
        |=> (q[i] == $past(q[i-1])));
    end
  end

  assign regOut   = q;
  assign carryOut = carry[NCELL];
  assign chainOut = q[NCELL-1];
endmodule

// File: rtl/lgc_cluster.sv
module lgc_cluster
  import lgc_pkg::*;
#(
  parameter int NCELL  = 16,
  parameter int LUT_IN = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         ena1,
  input  logic                         ena2,
  input  logic                         aclr1,
  input  logic                         aclr2,
  input  logic                         sclr,
  input  logic                         sload,
  input  logic                         useSload,
  input  logic [NCELL*(1<<LUT_IN)-1:0] cfgLut,
  input  logic [NCELL-1:0]             cfgArith,
  input  logic [NCELL-1:0]             cfgChain,
  input  logic [NCELL-1:0]             cfgPack,
  input  logic [NCELL-1:0]             cfgClkSel,
  input  logic [NCELL-1:0]             cfgClrSel,
  input  logic [NCELL-1:0]             dA,
  input  logic [NCELL-1:0]             dB,
  input  logic [NCELL-1:0]             dC,
  input  logic [NCELL-1:0]             dD,
  input  logic                         carryIn,
  input  logic                         chainIn,
  output logic [NCELL-1:0]             combOut,
  output logic [NCELL-1:0]             regOut,
  output logic                         carryOut,
  output logic                         chainOut,
  output logic                         cfgErr
);
  cellStb_t [NCELL-1:0] stb;

  lgc_ctrl #(.NCELL(NCELL)) u_ctrl (
    .clk(clk), .rstN(rstN), .ena1(ena1), .ena2(ena2),
    .aclr1(aclr1), .aclr2(aclr2), .sclr(sclr), .sload(sload),
    .useSload(useSload), .cfgClkSel(cfgClkSel), .cfgClrSel(cfgClrSel),
    .cfgPack(cfgPack), .stb(stb), .cfgErr(cfgErr)
  );

  lgc_cells #(.NCELL(NCELL), .LUT_IN(LUT_IN)) u_cells (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgLut(cfgLut),
    .cfgArith(cfgArith), .cfgChain(cfgChain), .cfgPack(cfgPack),
    .dA(dA), .dB(dB), .dC(dC), .dD(dD),
    .carryIn(carryIn), .chainIn(chainIn),
    .combOut(combOut), .regOut(regOut),
    .carryOut(carryOut), .chainOut(chainOut)
  );
endmodule

// File: tb/sim_lgc_cluster.sv
`timescale 1ns/1ps
module sim_lgc_cluster;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, ena1, ena2, aclr1, aclr2, sclr, sload, useSload;
  logic [255:0] cfgLut;
  logic [15:0] cfgArith, cfgChain, cfgPack, cfgClkSel, cfgClrSel;
  logic [15:0] dA, dB, dC, dD;
  logic carryIn, chainIn;
  logic [15:0] combOut, regOut;
  logic carryOut, chainOut, cfgErr;

  lgc_cluster u0 (.*);

  int nChk = 0;
  int nFail = 0;
  logic [15:0] mq = '0;
  bit addMode = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural combinational reference
  function automatic void refComb(output logic [15:0] s, output logic co);
    logic c = carryIn;
    for (int i = 0; i < 16; i++) begin
      if (cfgArith[i]) begin
        int t = int'(dA[i]) + int'(dB[i]) + int'(c);
        s[i] = t[0];
        c = t[1];
      end else begin
        s[i] = cfgLut[i*16 + int'({dD[i], dC[i], dB[i], dA[i]})];
      end
    end
    co = c;
  endfunction

  function automatic logic refErr();
    return useSload && ((~cfgClkSel) != 16'h0 || cfgPack != 16'h0);
  endfunction

  task automatic compare(input string tag);
    logic [15:0] s;
    logic co;
    refComb(s, co);
    chk({tag, " comb/carry/err"}, {14'h0, cfgErr, co, combOut}, {14'h0, refErr(), co, s});
    chk({tag, " reg/chain"}, {15'h0, chainOut, regOut}, {15'h0, mq[15], mq});
    if (addMode) begin
      logic [16:0] sum = 17'(dA) + 17'(dB) + 17'(carryIn);
      chk("R1 integer add", {15'h0, carryOut, combOut}, {15'h0, sum});
    end
  endtask

  task automatic cycle(input string tag);
    logic [15:0] s, old;
    logic co;
    @(posedge clk);
    refComb(s, co);
    old = mq;
    for (int i = 0; i < 16; i++) begin
      logic prev = (i == 0) ? chainIn : old[i-1];
      logic en = cfgClkSel[i] ? ena2 : (useSload || ena1);
      logic clr = !rstN || (cfgClrSel[i] ? aclr2 : aclr1);
      if (clr) mq[i] = 1'b0;
      else if (en) begin
        if (!cfgPack[i] && sclr) mq[i] = 1'b0;
        else if (!cfgPack[i] && useSload && sload) mq[i] = dC[i];
        else if (cfgPack[i]) mq[i] = dD[i];
        else if (cfgChain[i]) mq[i] = prev;
        else mq[i] = s[i];
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic randData();
    dA = 16'($urandom); dB = 16'($urandom); dC = 16'($urandom); dD = 16'($urandom);
    carryIn = 1'($urandom);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    #(200000 * 4);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic hist[$];
    rstN = 0; ena1 = 0; ena2 = 0; aclr1 = 0; aclr2 = 0; sclr = 0; sload = 0; useSload = 0;
    cfgLut = '0; cfgArith = '0; cfgChain = '0; cfgPack = '0; cfgClkSel = '1; cfgClrSel = '0;
    dA = '0; dB = '0; dC = '0; dD = '0; carryIn = 0; chainIn = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset regOut", {16'h0, regOut}, 32'h0);
    chk("R11 reset chainOut", {31'h0, chainOut}, 32'h0);
    chk("R12 reset cfgErr", {31'h0, cfgErr}, 32'h0);
    rstN = 1;

    // R1 R3: wide adder, registers capture the sum
    cfgArith = '1; ena2 = 1; addMode = 1;
    dA = 16'hFFFF; dB = 16'h0001; carryIn = 0; cycle("R1 R3 add ffff+1");
    dA = 16'hFFFF; dB = 16'h0000; carryIn = 1; cycle("R1 R3 add ffff+cin");
    dA = 16'h8000; dB = 16'h8000; carryIn = 0; cycle("R1 R3 add msb");
    dA = 16'h1234; dB = 16'h4321; carryIn = 1; cycle("R1 R3 add mixed");
    for (int k = 0; k < 8; k++) begin randData(); cycle("R1 R3 add random"); end
    addMode = 0;

    // R2: lookup mode, carry passes through
    cfgArith = '0;
    for (int i = 0; i < 16; i++) cfgLut[i*16 +: 16] = 16'h8000;
    dA = '1; dB = '1; dC = '1; dD = 16'h00FF; carryIn = 1; cycle("R2 and4 mask");
    for (int i = 0; i < 16; i++) cfgLut[i*16 +: 16] = 16'h6996;
    randData(); cycle("R2 parity mask");
    for (int k = 0; k < 8; k++) begin
      cfgLut = {8{32'($urandom)}}; randData(); cycle("R2 R3 random mask");
    end

    // R4: 16-stage shift through the chain
    cfgChain = '1;
    for (int k = 0; k < 24; k++) begin
      randData(); chainIn = 1'($urandom);
      hist.push_back(chainIn);
      cycle("R4 shift");
      if (hist.size() >= 16) chk("R4 chain delay", {31'h0, chainOut}, {31'h0, hist[hist.size()-16]});
    end
    cfgChain = '0;

    // R6: two enable slots
    cfgClkSel = 16'hAAAA;
    ena1 = 0; ena2 = 0; randData(); sclr = 1; cycle("R6 both off");
    sclr = 0;
    for (int k = 0; k < 12; k++) begin
      randData(); ena1 = 1'($urandom); ena2 = 1'($urandom); cycle("R6 random enables");
    end

    // R5 R7: packed cells and synchronous clear
    cfgPack = 16'h0F0F; ena1 = 1; ena2 = 1;
    randData(); cycle("R5 packed capture");
    sclr = 1; randData(); cycle("R5 R7 sclr");
    for (int k = 0; k < 8; k++) begin
      randData(); sclr = 1'($urandom); ena1 = 1'($urandom); ena2 = 1'($urandom);
      cycle("R5 R6 R7 mixed");
    end
    sclr = 0; cfgPack = '0;

    // R8 R9 R12: synchronous load
    useSload = 1; cfgClkSel = '1; ena1 = 0; ena2 = 1;
    sload = 1; randData(); cycle("R8 R12 load legal");
    sclr = 1; randData(); cycle("R7 R8 sclr over load");
    sclr = 0;
    for (int k = 0; k < 6; k++) begin
      randData(); sload = 1'($urandom); cycle("R8 random load");
    end
    cfgClkSel = 16'hFFFE; ena1 = 0; sload = 0; randData(); cycle("R9 R12 slot1 ena ignored");
    cfgClkSel = '1; cfgPack = 16'h0010; sload = 1; randData(); cycle("R5 R12 pack with load");
    cfgPack = '0; useSload = 0; sload = 1; ena1 = 1; randData(); cycle("R8 R12 load off ignored");
    sload = 0;

    // R10: asynchronous clears per selected line
    cfgClrSel = 16'h00FF;
    dA = '1; dB = '0; cfgArith = '1; carryIn = 0; cycle("R3 fill ones");
    cfgArith = '0;
    aclr1 = 1; #1;
    for (int i = 0; i < 16; i++) if (!cfgClrSel[i]) mq[i] = 1'b0;
    chk("R10 aclr1 immediate", {16'h0, regOut}, {16'h0, mq});
    cycle("R10 aclr1 held");
    aclr1 = 0;
    cfgArith = '1; dA = '1; cycle("R3 refill");
    cfgArith = '0;
    aclr2 = 1; #1;
    for (int i = 0; i < 16; i++) if (cfgClrSel[i]) mq[i] = 1'b0;
    chk("R10 aclr2 immediate", {16'h0, regOut}, {16'h0, mq});
    cycle("R10 aclr2 held");
    aclr2 = 0;

    // R11: global reset mid-run overrides everything
    cfgArith = '1; dA = '1; cycle("R3 refill");
    rstN = 0; useSload = 1; sload = 1; dC = '1; #1;
    mq = '0;
    chk("R11 reset immediate", {16'h0, regOut}, 32'h0);
    cycle("R11 reset held");
    rstN = 1; useSload = 0; sload = 0;
    randData(); cycle("R1 after reset");

    summary();
    $finish;
  end
endmodule